// File: doc/BRIEF.md
# Inverse Rotation Source Coordinate Generator

This block walks an output image in raster order and, for every output pixel, works out where that pixel comes from in the input image. The output position is first moved so that it is measured from the output image centre, and a translation offset is subtracted. The result is multiplied by a 2x2 rotation matrix and the input image centre is added back. All arithmetic is signed fixed point with 32 bits in total and 16 fractional bits. For an anticlockwise rotation by an angle, the matrix rows are (cos, sin) and (-sin, cos); sine and cosine are computed elsewhere.

Each source point is split into its lower integer neighbour, the neighbour one step above it, and the fractional distance from the lower neighbour, on both axes. A flag tells whether all four neighbours lie inside the input image, so that a downstream fetch and interpolation stage can either blend four pixels or emit a fill value. One coordinate leaves the block on every clock after a fixed pipeline latency. A single-cycle pulse marks the end of the frame.

The first source axis (x) runs along the input rows (the height) and follows the output row index. The second source axis (y) runs along the input columns (the width) and follows the output column index.

Top module: `rot_coord_gen`

## Requirements
- R1: Output pixels leave in raster order, with the row index i as the outer loop over OUT_H and the column index j as the inner loop over OUT_W. pix_idx_o equals i*OUT_W+j: it is 0 on the first valid of a frame and rises by one on every following valid.
- R2: Count the rising edge that samples an accepted start_i as edge 1. valid_o is first high after edge 5 and then stays high for exactly OUT_H*OUT_W consecutive cycles, with no gap.
- R3: Let u = (i - OUT_H/2)·2^16 - shift_row_i and v = (j - OUT_W/2)·2^16 - shift_col_i, both wrapped to 32 bits. The source coordinate x equals floor((u·rot_m0_i + v·rot_m1_i)/2^16) + (IN_H/2)·2^16, and y equals floor((u·rot_m2_i + v·rot_m3_i)/2^16) + (IN_W/2)·2^16. Both are in Q16.16 and wrap to 32 bits. All halvings of image sizes round down.
- R4: src_x0_o is the 17-bit signed integer part of x (bits 31:16, sign extended), src_x1_o = src_x0_o + 1, and frac_x_o is bits 15:0 of x read as an unsigned fraction. The y outputs follow the same rules from y.
- R5: in_bounds_o is 1 exactly when src_x0_o >= 0, src_y0_o >= 0, src_x1_o < IN_H and src_y1_o < IN_W. A source point whose integer part equals IN_H-1 or IN_W-1 is therefore out of bounds.
- R6: done_o is high for one cycle, in the cycle right after the last valid pixel, and valid_o is low in that cycle.
- R7: The four matrix inputs and the two shift inputs are captured when start is accepted. Changing them during a frame does not change any output of that frame.
- R8: start_i is ignored from the accepting edge through the cycle in which done_o is high. A start in that window neither restarts nor lengthens the frame.
- R9: While rst_ni is low, valid_o, done_o, in_bounds_o and all coordinate, fraction and index outputs are 0.
- R10: A negative source coordinate rounds toward minus infinity. For example, x = -2.25 gives src_x0_o = -3, src_x1_o = -2 and frac_x_o = 16'hC000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a frame when the block is idle |
| rot_m0_i | input | 32 | Matrix entry, row-offset term of x, Q16.16 signed |
| rot_m1_i | input | 32 | Matrix entry, column-offset term of x, Q16.16 signed |
| rot_m2_i | input | 32 | Matrix entry, row-offset term of y, Q16.16 signed |
| rot_m3_i | input | 32 | Matrix entry, column-offset term of y, Q16.16 signed |
| shift_col_i | input | 32 | Translation subtracted from the column offset, Q16.16 signed |
| shift_row_i | input | 32 | Translation subtracted from the row offset, Q16.16 signed |
| valid_o | output | 1 | Coordinate outputs hold a pixel |
| in_bounds_o | output | 1 | All four neighbours lie inside the input image |
| pix_idx_o | output | $clog2(OUT_H*OUT_W) | Output pixel index i*OUT_W+j |
| src_x0_o | output | 17 | Lower integer neighbour on x, signed |
| src_x1_o | output | 17 | Upper integer neighbour on x, signed |
| src_y0_o | output | 17 | Lower integer neighbour on y, signed |
| src_y1_o | output | 17 | Upper integer neighbour on y, signed |
| frac_x_o | output | 16 | Distance from src_x0_o, unsigned fraction |
| frac_y_o | output | 16 | Distance from src_y0_o, unsigned fraction |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
A raster counter that skips or repeats a step shows at once as a break in pix_idx_o, and the source coordinates of the next pixel go wrong with it. A product or sum that is off by one bit in a pipeline stage shows up in frac_x_o or frac_y_o on the first pixel whose offsets are not zero, four cycles after that pixel leaves the raster walk. A wrong floor or a wrong bounds compare shows on the rows or columns that land below zero or on the last input row or column, so the directed frames place source points there on purpose. Capture or busy logic that lets a start slip in shows as a changed coordinate or an extra valid in the same frame.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int FIX_W  = 32;
  localparam int FRAC_W = 16;
  localparam int CRD_W  = FIX_W - FRAC_W + 1;
  localparam int PROD_W = FIX_W + FRAC_W;

  typedef enum logic [0:0] {WALK_IDLE, WALK_RUN} walk_state_e;

  typedef struct packed {
    logic [FIX_W-1:0] m0;
    logic [FIX_W-1:0] m1;
    logic [FIX_W-1:0] m2;
    logic [FIX_W-1:0] m3;
    logic [FIX_W-1:0] sh_col;
    logic [FIX_W-1:0] sh_row;
  } coef_t;
endpackage

// File: rtl/rot_raster_walk.sv
module rot_raster_walk
  import rot_pkg::*;
#(
  parameter int OUT_H = 12,
  parameter int OUT_W = 10,
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  output logic             vld_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  walk_state_e      state_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [IDX_W-1:0] idx_q;
  logic             row_end, col_end;

  assign row_end = row_q == ROW_W'(OUT_H - 1);
  assign col_end = col_q == COL_W'(OUT_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WALK_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      idx_q   <= '0;
    end else if (accept_i) begin
      state_q <= WALK_RUN;
      row_q   <= '0;
      col_q   <= '0;
      idx_q   <= '0;
    end else if (state_q == WALK_RUN) begin
      idx_q <= idx_q + IDX_W'(1);
      if (col_end) begin
        col_q <= '0;
        if (row_end) begin
          state_q <= WALK_IDLE;
          row_q   <= '0;
          idx_q   <= '0;
        end else begin
          row_q <= row_q + ROW_W'(1);
        end
      end else begin
        col_q <= col_q + COL_W'(1);
      end
    end
  end

  assign vld_o  = state_q == WALK_RUN;
  assign row_o  = row_q;
  assign col_o  = col_q;
  assign idx_o  = idx_q;
  assign last_o = vld_o && row_end && col_end;

  AST_ROW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (row_q < ROW_W'(OUT_H)) && (col_q < COL_W'(OUT_W))); // R1
  AST_ACCEPT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |-> state_q == WALK_IDLE); // R8
  AST_WALK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && !last_o |=> vld_o && idx_q == $past(idx_q) + IDX_W'(1)); // R2
endmodule

// File: rtl/rot_affine_pipe.sv
module rot_affine_pipe
  import rot_pkg::*;
#(
  parameter int OUT_H = 12,
  parameter int OUT_W = 10,
  parameter int IN_H  = 9,
  parameter int IN_W  = 14,
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  coef_t            coef_i,
  input  logic             vld_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             last_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o,
  output logic [FIX_W-1:0] x_o,
  output logic [FIX_W-1:0] y_o,
  output logic             active_o
);
  localparam int STAGES = 3;
  localparam logic signed [FIX_W-1:0] OH_HALF = FIX_W'(OUT_H / 2);
  localparam logic signed [FIX_W-1:0] OW_HALF = FIX_W'(OUT_W / 2);
  localparam logic signed [FIX_W-1:0] IH_HALF = FIX_W'((IN_H / 2) * (2 ** FRAC_W));
  localparam logic signed [FIX_W-1:0] IW_HALF = FIX_W'((IN_W / 2) * (2 ** FRAC_W));

  logic             vld_q  [STAGES];
  logic [IDX_W-1:0] idx_q  [STAGES];
  logic             last_q [STAGES];

  // stage 1: centre and translate
  logic signed [FIX_W-1:0] row_off, col_off, u_c, v_c, u_q, v_q;
  assign row_off = $signed({{(FIX_W-ROW_W){1'b0}}, row_i}) - OH_HALF;
  assign col_off = $signed({{(FIX_W-COL_W){1'b0}}, col_i}) - OW_HALF;
  assign u_c = (row_off <<< FRAC_W) - $signed(coef_i.sh_row);
  assign v_c = (col_off <<< FRAC_W) - $signed(coef_i.sh_col);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      u_q <= '0;
      v_q <= '0;
    end else begin
      u_q <= u_c;
      v_q <= v_c;
    end
  end

  // stage 2: four products, kept to the bits that reach the result
  logic signed [FIX_W-1:0]  fac_c  [4];
  logic signed [FIX_W-1:0]  mat_c  [4];
  logic signed [PROD_W-1:0] prod_q [4];
  assign mat_c[0] = $signed(coef_i.m0);
  assign mat_c[1] = $signed(coef_i.m1);
  assign mat_c[2] = $signed(coef_i.m2);
  assign mat_c[3] = $signed(coef_i.m3);

  for (genvar k = 0; k < 4; k++) begin : g_mul
    logic signed [PROD_W-1:0] prod_c;
    assign fac_c[k] = (k % 2 == 0) ? u_q : v_q;
    assign prod_c   = PROD_W'(fac_c[k]) * PROD_W'(mat_c[k]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prod_q[k] <= '0;
      else         prod_q[k] <= prod_c;
    end
  end

  // stage 3: sum, floor to Q16.16, re-centre on input image
  logic signed [PROD_W-1:0] sx_c, sy_c;
  logic [FIX_W-1:0]         x_q, y_q;
  logic                     unused_frac;
  assign sx_c = prod_q[0] + prod_q[1];
  assign sy_c = prod_q[2] + prod_q[3];
  assign unused_frac = ^{sx_c[FRAC_W-1:0], sy_c[FRAC_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      x_q <= sx_c[FRAC_W +: FIX_W] + IH_HALF;
      y_q <= sy_c[FRAC_W +: FIX_W] + IW_HALF;
    end
  end

  // tag pipeline
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) begin
        vld_q[s]  <= 1'b0;
        idx_q[s]  <= '0;
        last_q[s] <= 1'b0;
      end
    end else begin
      vld_q[0]  <= vld_i;
      idx_q[0]  <= idx_i;
      last_q[0] <= last_i;
      for (int s = 1; s < STAGES; s++) begin
        vld_q[s]  <= vld_q[s-1];
        idx_q[s]  <= idx_q[s-1];
        last_q[s] <= last_q[s-1];
      end
    end
  end

  always_comb begin
    active_o = 1'b0;
    for (int s = 0; s < STAGES; s++) active_o = active_o | vld_q[s];
  end

  assign vld_o  = vld_q[STAGES-1];
  assign idx_o  = idx_q[STAGES-1];
  assign last_o = last_q[STAGES-1];
  assign x_o    = x_q;
  assign y_o    = y_q;

  AST_TAG_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q[1] && vld_q[0] |-> idx_q[0] == idx_q[1] + IDX_W'(1)); // R1
  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && last_o |=> !vld_o); // R2
endmodule

// File: rtl/rot_neighbour_split.sv
module rot_neighbour_split
  import rot_pkg::*;
#(
  parameter int IN_H  = 9,
  parameter int IN_W  = 14,
  parameter int IDX_W = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic                    last_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [FIX_W-1:0]        x_i,
  input  logic [FIX_W-1:0]        y_i,
  output logic                    valid_o,
  output logic                    in_bounds_o,
  output logic [IDX_W-1:0]        pix_idx_o,
  output logic signed [CRD_W-1:0] lo_o [2],
  output logic signed [CRD_W-1:0] hi_o [2],
  output logic [FRAC_W-1:0]       frac_o [2],
  output logic                    done_o
);
  logic [FIX_W-1:0] fix_c [2];
  logic [1:0]       ok_c;
  logic             vld_q, last_q, inb_q, done_q;
  logic [IDX_W-1:0] idx_q;

  assign fix_c[0] = x_i;
  assign fix_c[1] = y_i;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    localparam int LIM = (a == 0) ? IN_H : IN_W;
    logic signed [CRD_W-1:0] lo_c, hi_c;
    logic signed [CRD_W-1:0] lo_q, hi_q;
    logic [FRAC_W-1:0]       fr_q;

    assign lo_c    = $signed({fix_c[a][FIX_W-1], fix_c[a][FIX_W-1:FRAC_W]});
    assign hi_c    = lo_c + CRD_W'(1);
    assign ok_c[a] = !lo_c[CRD_W-1] && (hi_c < CRD_W'(LIM));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= '0;
        hi_q <= '0;
        fr_q <= '0;
      end else begin
        lo_q <= lo_c;
        hi_q <= hi_c;
        fr_q <= fix_c[a][FRAC_W-1:0];
      end
    end

    assign lo_o[a]   = vld_q ? lo_q : '0;
    assign hi_o[a]   = vld_q ? hi_q : '0;
    assign frac_o[a] = vld_q ? fr_q : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      inb_q  <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      vld_q  <= vld_i;
      last_q <= last_i;
      inb_q  <= vld_i && (&ok_c);
      idx_q  <= vld_i ? idx_i : '0;
      done_q <= vld_q && last_q;
    end
  end

  assign valid_o     = vld_q;
  assign in_bounds_o = inb_q;
  assign pix_idx_o   = idx_q;
  assign done_o      = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_o) && !valid_o); // R6
  AST_BOUNDS_ONLY_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_bounds_o |-> valid_o); // R5
endmodule

// File: rtl/rot_coord_gen.sv
module rot_coord_gen
  import rot_pkg::*;
#(
  parameter int OUT_H = 12,
  parameter int OUT_W = 10,
  parameter int IN_H  = 9,
  parameter int IN_W  = 14,
  localparam int NPIX  = OUT_H * OUT_W,
  localparam int IDX_W = (NPIX > 1) ? $clog2(NPIX) : 1,
  localparam int ROW_W = $clog2(OUT_H + 1),
  localparam int COL_W = $clog2(OUT_W + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [FIX_W-1:0]        rot_m0_i,
  input  logic [FIX_W-1:0]        rot_m1_i,
  input  logic [FIX_W-1:0]        rot_m2_i,
  input  logic [FIX_W-1:0]        rot_m3_i,
  input  logic [FIX_W-1:0]        shift_col_i,
  input  logic [FIX_W-1:0]        shift_row_i,
  output logic                    valid_o,
  output logic                    in_bounds_o,
  output logic [IDX_W-1:0]        pix_idx_o,
  output logic signed [CRD_W-1:0] src_x0_o,
  output logic signed [CRD_W-1:0] src_x1_o,
  output logic signed [CRD_W-1:0] src_y0_o,
  output logic signed [CRD_W-1:0] src_y1_o,
  output logic [FRAC_W-1:0]       frac_x_o,
  output logic [FRAC_W-1:0]       frac_y_o,
  output logic                    done_o
);
  coef_t            coef_q;
  logic             busy, accept;
  logic             w_vld, w_last, a_vld, a_last, a_active;
  logic [ROW_W-1:0] w_row;
  logic [COL_W-1:0] w_col;
  logic [IDX_W-1:0] w_idx, a_idx;
  logic [FIX_W-1:0] a_x, a_y;
  logic signed [CRD_W-1:0] lo [2];
  logic signed [CRD_W-1:0] hi [2];
  logic [FRAC_W-1:0]       fr [2];

  // busy covers the whole frame, drain and done cycle included
  assign busy   = w_vld || a_active || valid_o || done_o;
  assign accept = start_i && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coef_q <= '0;
    end else if (accept) begin
      coef_q <= '{m0: rot_m0_i, m1: rot_m1_i, m2: rot_m2_i, m3: rot_m3_i,
                  sh_col: shift_col_i, sh_row: shift_row_i};
    end
  end

  rot_raster_walk #(
    .OUT_H(OUT_H), .OUT_W(OUT_W), .ROW_W(ROW_W), .COL_W(COL_W), .IDX_W(IDX_W)
  ) i_walk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .vld_o    (w_vld),
    .row_o    (w_row),
    .col_o    (w_col),
    .idx_o    (w_idx),
    .last_o   (w_last)
  );

  rot_affine_pipe #(
    .OUT_H(OUT_H), .OUT_W(OUT_W), .IN_H(IN_H), .IN_W(IN_W),
    .ROW_W(ROW_W), .COL_W(COL_W), .IDX_W(IDX_W)
  ) i_affine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .coef_i   (coef_q),
    .vld_i    (w_vld),
    .row_i    (w_row),
    .col_i    (w_col),
    .idx_i    (w_idx),
    .last_i   (w_last),
    .vld_o    (a_vld),
    .idx_o    (a_idx),
    .last_o   (a_last),
    .x_o      (a_x),
    .y_o      (a_y),
    .active_o (a_active)
  );

  rot_neighbour_split #(
    .IN_H(IN_H), .IN_W(IN_W), .IDX_W(IDX_W)
  ) i_split (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vld_i       (a_vld),
    .last_i      (a_last),
    .idx_i       (a_idx),
    .x_i         (a_x),
    .y_i         (a_y),
    .valid_o     (valid_o),
    .in_bounds_o (in_bounds_o),
    .pix_idx_o   (pix_idx_o),
    .lo_o        (lo),
    .hi_o        (hi),
    .frac_o      (fr),
    .done_o      (done_o)
  );

  assign src_x0_o = lo[0];
  assign src_x1_o = hi[0];
  assign src_y0_o = lo[1];
  assign src_y1_o = hi[1];
  assign frac_x_o = fr[0];
  assign frac_y_o = fr[1];

  AST_IDX_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> pix_idx_o == '0); // R1
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_o) |-> pix_idx_o == $past(pix_idx_o) + IDX_W'(1)); // R1
  AST_NO_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> done_o); // R2
  AST_COEF_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(coef_q)); // R7
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && valid_o |=> !$rose(w_vld)); // R8
endmodule

// File: tb/test_rot_coord_gen.sv
module test_rot_coord_gen;
  localparam int OH = 12;
  localparam int OW = 10;
  localparam int IH = 9;
  localparam int IW = 14;
  localparam int NP = OH * OW;
  localparam int IDX_W = $clog2(NP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] m0 = '0, m1 = '0, m2 = '0, m3 = '0, sc = '0, sr = '0;
  logic valid, inb, done;
  logic [IDX_W-1:0] pidx;
  logic signed [16:0] x0, x1, y0, y1;
  logic [15:0] fx, fy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rot_coord_gen #(.OUT_H(OH), .OUT_W(OW), .IN_H(IH), .IN_W(IW)) i_rot_coord_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .rot_m0_i(m0), .rot_m1_i(m1), .rot_m2_i(m2), .rot_m3_i(m3),
    .shift_col_i(sc), .shift_row_i(sr),
    .valid_o(valid), .in_bounds_o(inb), .pix_idx_o(pidx),
    .src_x0_o(x0), .src_x1_o(x1), .src_y0_o(y0), .src_y1_o(y1),
    .frac_x_o(fx), .frac_y_o(fy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic calc(input int i, input int j, input logic signed [31:0] ma,
                      input logic signed [31:0] mb, input logic signed [31:0] tr,
                      input logic signed [31:0] tc, input int half, input int lim,
                      output logic signed [16:0] lo, output logic signed [16:0] hi,
                      output logic [15:0] fr, output bit ok);
    logic signed [31:0] uf, vf, f;
    longint s;
    uf = 32'((i - OH / 2) * 65536) - tr;
    vf = 32'((j - OW / 2) * 65536) - tc;
    s  = longint'(uf) * longint'(ma) + longint'(vf) * longint'(mb);
    f  = 32'(s >>> 16) + 32'(half * 65536);
    lo = 17'(f >>> 16);
    hi = lo + 17'sd1;
    fr = f[15:0];
    ok = (lo >= 0) && (hi < lim);
  endtask

  task automatic run_frame(input logic [31:0] a0, input logic [31:0] a1,
                           input logic [31:0] a2, input logic [31:0] a3,
                           input logic [31:0] tc, input logic [31:0] tr,
                           input bit disturb);
    int seen = 0;
    int dones = 0;
    @(negedge clk);
    m0 = a0; m1 = a1; m2 = a2; m3 = a3; sc = tc; sr = tr;
    start = 1'b1;
    for (int cyc = 1; cyc <= NP + 12; cyc++) begin
      @(posedge clk);
      @(negedge clk);
      if (cyc == 1) start = 1'b0;
      if (disturb && cyc == 20) begin
        // R7 R8: new values and a start while the frame runs
        start = 1'b1;
        m0 = ~a0; m1 = a1 + 32'h1234; m2 = ~a2; m3 = a3 ^ 32'h00ff_0000;
        sc = tc + 32'h0003_0000; sr = tr - 32'h0002_8000;
      end
      if (disturb && cyc == 21) start = 1'b0;
      if (cyc == 4) chk(valid == 1'b0, "R2", "valid before latency", valid, 0);
      if (valid) begin
        logic signed [16:0] ex0, ex1, ey0, ey1;
        logic [15:0] efx, efy;
        bit okx, oky;
        int i = seen / OW;
        int j = seen % OW;
        if (seen == 0) chk(cyc == 5, "R2", "first valid cycle", cyc, 5);
        if (seen >= NP) begin
          chk(1'b0, "R8", "extra valid pixel", seen, NP - 1);
        end else begin
          calc(i, j, a0, a1, tr, tc, IH / 2, IH, ex0, ex1, efx, okx);
          calc(i, j, a2, a3, tr, tc, IW / 2, IW, ey0, ey1, efy, oky);
          chk(pidx == IDX_W'(seen), "R1", "pixel index", pidx, seen);
          chk({x0, x1, fx} == {ex0, ex1, efx}, "R3 R4 R7 R10", "x neighbours/frac",
              {x0, x1, fx}, {ex0, ex1, efx});
          chk({y0, y1, fy} == {ey0, ey1, efy}, "R3 R4 R7", "y neighbours/frac",
              {y0, y1, fy}, {ey0, ey1, efy});
          chk(inb == (okx && oky), "R5", "in bounds flag", inb, okx && oky);
        end
        seen++;
      end
      if (done) begin
        dones++;
        chk(seen == NP && !valid, "R6", "done after last pixel", seen, NP);
      end
    end
    chk(seen == NP, "R2", "valid count per frame", seen, NP);
    chk(dones == 1, "R6", "done pulse count", dones, 1);
  endtask

  function automatic logic [31:0] rnd_coef();
    return 32'($signed($urandom_range(0, 262144)) - 131072);
  endfunction

  function automatic logic [31:0] rnd_shift();
    return 32'($signed($urandom_range(0, 2097152)) - 1048576);
  endfunction

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    // R9 reset values
    chk({valid, inb, done} == 3'b000, "R9", "flags in reset", {valid, inb, done}, 0);
    chk({pidx, x0, x1, y0, y1, fx, fy} == '0, "R9", "data in reset", pidx, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // identity: x = i-2 reaches -2 and IN_H-1 (out of bounds corner, R5)
    run_frame(32'h0001_0000, 0, 0, 32'h0001_0000, 0, 0, 1'b0);
    // R10: quarter-pixel row shift gives negative fractional x
    run_frame(32'h0001_0000, 0, 0, 32'h0001_0000, 32'hffff_8000, 32'h0000_4000, 1'b0);
    // quarter turn
    run_frame(0, 32'h0001_0000, 32'hffff_0000, 0, 32'h0001_0000, 0, 1'b0);
    // R7 R8: disturbed frame with a rotation near 30 degrees
    run_frame(32'h0000_ddb4, 32'h0000_8000, 32'hffff_8000, 32'h0000_ddb4,
              32'h0000_2000, 32'hffff_c000, 1'b1);
    for (int f = 0; f < 4; f++) begin
      run_frame(rnd_coef(), rnd_coef(), rnd_coef(), rnd_coef(),
                rnd_shift(), rnd_shift(), f == 2);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule